// File: doc/BRIEF.md
# Sample Width Converter with Rounding and Clipping

This block sits between an 8-bit sample interface and a 16-bit two's-complement processing core. It carries two independent datapaths. The widening path takes a signed 8-bit sample and places it inside a 16-bit word. The sample's sign is copied into any headroom bits above it, and the bits below it are cleared. The narrowing path takes a 16-bit core result and turns it back into an 8-bit sample. It can round before truncating, it drops the same headroom bits, and it clips to the largest or smallest 8-bit code instead of wrapping.

Both paths share one static headroom setting, `cfg_guard` (0 to 8), and one static rounding enable. Each path has one register stage. A valid strobe at the input gives a valid strobe at the output one clock later. The output data holds its last value while no new sample arrives.

The narrowing path sorts each result into one of three named outcomes:
- `CLIP_NONE`: the value fits in 8 bits and passes through.
- `CLIP_HIGH`: the value is above +127, so the output is 0x7F.
- `CLIP_LOW`: the value is below -128, so the output is 0x80.

The outcome is chosen fresh for every sample with no carried state. Any outcome can follow any other. An accepted sample moves the registered output to the outcome's code, and a cycle without a valid input leaves the output data unchanged.

Top module: `smp_width_conv`

## Requirements
- R1: With `cfg_guard` = 0, the widened output equals the input byte in bits [15:8] with bits [7:0] zero.
- R2: With `cfg_guard` = G in 1..8, the widened output holds the input at bits [15-G:8-G]. Bits above it are copies of input bit 7, and bits below it are zero.
- R3: With rounding off, the narrowed output is bits [15-G:8-G] of the input whenever that field, read as a signed value, equals the arithmetic right shift of the input by 8-G.
- R4: With rounding on and G < 8, 2^(7-G) is added to the sign-extended input before the shift. With G = 8, rounding has no effect.
- R5: A narrowed result above +127 gives 0x7F, and one below -128 gives 0x80. A carry out of the top caused by rounding also clips high and never wraps.
- R6: `nar_out_ovf` is 1 exactly in the output-valid cycle of a clipped sample, and 0 otherwise.
- R7: Each output valid is its input valid delayed by one clock. Output data changes only in the cycle after an input valid.
- R8: While reset is active, and in the first cycle after it, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_guard | input | 4 | Headroom bits above the 8-bit sample (0..8), static |
| cfg_round | input | 1 | Round-half-up enable for the narrowing path, static |
| wide_in_vld | input | 1 | Widening path input valid |
| wide_in_dat | input | 8 | Signed 8-bit sample |
| wide_out_vld | output | 1 | Widening path output valid |
| wide_out_dat | output | 16 | Widened 16-bit sample |
| nar_in_vld | input | 1 | Narrowing path input valid |
| nar_in_dat | input | 16 | Signed 16-bit core result |
| nar_out_vld | output | 1 | Narrowing path output valid |
| nar_out_dat | output | 8 | Narrowed 8-bit sample |
| nar_out_ovf | output | 1 | Clip flag, aligned with `nar_out_vld` |

## Verification
The assertions take for granted that `cfg_guard` never exceeds 8. They also assume that both configuration inputs are held steady while a sample is in flight, since the registered result is judged against the setting that produced it. The stimulus only changes configuration in cycles with both valids low. It uses headroom values from 0 to 8 and covers both signs, both clip directions, and the rounding carry into the top bit.

// File: rtl/sw_pkg.sv
package sw_pkg;
    typedef enum logic [1:0] {
        CLIP_NONE = 2'd0,
        CLIP_HIGH = 2'd1,
        CLIP_LOW  = 2'd2
    } clip_e;
endpackage

// File: rtl/sw_widen.sv
module sw_widen #(
    parameter int IN_W    = 8,
    parameter int CORE_W  = 16,
    parameter int GUARD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GUARD_W-1:0] guard,
    input  logic               in_vld,
    input  logic [IN_W-1:0]    in_dat,
    output logic               out_vld,
    output logic [CORE_W-1:0]  out_dat
);
    localparam int MAX_G = CORE_W - IN_W;

    logic [GUARD_W-1:0] shamt;
    logic [CORE_W-1:0]  ext;
    logic [CORE_W-1:0]  placed;

    // Sign-extend the sample, then lift it so that its MSB lands at 15-G.
    always_comb begin
        shamt  = GUARD_W'(MAX_G) - guard;
        ext    = {{(CORE_W-IN_W){in_dat[IN_W-1]}}, in_dat};
        placed = ext << shamt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_dat <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) out_dat <= placed;
        end
    end

    AST_WIDE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);                                          // R7
    AST_WIDE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && $stable(out_dat)));                  // R7
    AST_WIDE_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (out_dat[CORE_W-1] == $past(in_dat[IN_W-1])));     // R2
    AST_WIDE_LOWZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && guard == '0) |=> (out_dat[MAX_G-1:0] == '0));      // R1
endmodule

// File: rtl/sw_narrow.sv
module sw_narrow
    import sw_pkg::*;
#(
    parameter int IN_W    = 16,
    parameter int OUT_W   = 8,
    parameter int GUARD_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GUARD_W-1:0] guard,
    input  logic               round_en,
    input  logic               in_vld,
    input  logic [IN_W-1:0]    in_dat,
    output logic               out_vld,
    output logic [OUT_W-1:0]   out_dat,
    output logic               out_ovf
);
    localparam int MAX_G = IN_W - OUT_W;
    localparam int EXT_W = IN_W + 1;
    localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [EXT_W-1:0] NEG_LIM = -POS_LIM - EXT_W'(1);
    localparam logic [OUT_W-1:0] CODE_HI = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] CODE_LO = {1'b1, {(OUT_W-1){1'b0}}};

    logic [GUARD_W-1:0]       shamt;
    logic signed [EXT_W-1:0]  rnd;
    logic signed [EXT_W-1:0]  sum;
    logic signed [EXT_W-1:0]  shifted;
    clip_e                    clip;
    logic [OUT_W-1:0]         code;

    // Rounding is done one bit wider so that a carry past the top is kept.
    always_comb begin
        shamt = GUARD_W'(MAX_G) - guard;
        rnd   = '0;
        if (round_en && (guard < GUARD_W'(MAX_G)))
            rnd = EXT_W'(1) << (shamt - GUARD_W'(1));
        sum     = $signed({in_dat[IN_W-1], in_dat}) + rnd;
        shifted = sum >>> shamt;
    end

    // Sort the shifted value into one of the three outcomes.
    always_comb begin
        if (shifted > POS_LIM)      clip = CLIP_HIGH;
        else if (shifted < NEG_LIM) clip = CLIP_LOW;
        else                        clip = CLIP_NONE;
    end

    always_comb begin
        unique case (clip)
            CLIP_HIGH: code = CODE_HI;
            CLIP_LOW:  code = CODE_LO;
            default:   code = shifted[OUT_W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_dat <= '0;
            out_ovf <= 1'b0;
        end else begin
            out_vld <= in_vld;
            out_ovf <= in_vld && (clip != CLIP_NONE);
            if (in_vld) out_dat <= code;
        end
    end

    AST_NAR_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);                                          // R7
    AST_NAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && $stable(out_dat)));                  // R7
    AST_OVF_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> out_vld);                                         // R6
    AST_SAT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> (out_dat == CODE_HI || out_dat == CODE_LO));      // R5
    AST_SAT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (!out_ovf || out_dat[OUT_W-1] == $past(in_dat[IN_W-1]))); // R5
endmodule

// File: rtl/smp_width_conv.sv
module smp_width_conv #(
    parameter int SMP_W   = 8,
    parameter int CORE_W  = 16,
    parameter int GUARD_W = $clog2(CORE_W - SMP_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GUARD_W-1:0] cfg_guard,
    input  logic               cfg_round,
    input  logic               wide_in_vld,
    input  logic [SMP_W-1:0]   wide_in_dat,
    output logic               wide_out_vld,
    output logic [CORE_W-1:0]  wide_out_dat,
    input  logic               nar_in_vld,
    input  logic [CORE_W-1:0]  nar_in_dat,
    output logic               nar_out_vld,
    output logic [SMP_W-1:0]   nar_out_dat,
    output logic               nar_out_ovf
);
    sw_widen #(
        .IN_W    (SMP_W),
        .CORE_W  (CORE_W),
        .GUARD_W (GUARD_W)
    ) u_widen (
        .clk     (clk),
        .rst_n   (rst_n),
        .guard   (cfg_guard),
        .in_vld  (wide_in_vld),
        .in_dat  (wide_in_dat),
        .out_vld (wide_out_vld),
        .out_dat (wide_out_dat)
    );

    sw_narrow #(
        .IN_W    (CORE_W),
        .OUT_W   (SMP_W),
        .GUARD_W (GUARD_W)
    ) u_narrow (
        .clk      (clk),
        .rst_n    (rst_n),
        .guard    (cfg_guard),
        .round_en (cfg_round),
        .in_vld   (nar_in_vld),
        .in_dat   (nar_in_dat),
        .out_vld  (nar_out_vld),
        .out_dat  (nar_out_dat),
        .out_ovf  (nar_out_ovf)
    );
endmodule

// File: tb/smp_width_conv_tb.sv
`timescale 1ns/1ps
module smp_width_conv_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_guard = '0;
    logic        cfg_round = 1'b0;
    logic        wide_in_vld = 1'b0;
    logic [7:0]  wide_in_dat = '0;
    logic        wide_out_vld;
    logic [15:0] wide_out_dat;
    logic        nar_in_vld = 1'b0;
    logic [15:0] nar_in_dat = '0;
    logic        nar_out_vld;
    logic [7:0]  nar_out_dat;
    logic        nar_out_ovf;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    smp_width_conv u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_guard(cfg_guard), .cfg_round(cfg_round),
        .wide_in_vld(wide_in_vld), .wide_in_dat(wide_in_dat),
        .wide_out_vld(wide_out_vld), .wide_out_dat(wide_out_dat),
        .nar_in_vld(nar_in_vld), .nar_in_dat(nar_in_dat),
        .nar_out_vld(nar_out_vld), .nar_out_dat(nar_out_dat), .nar_out_ovf(nar_out_ovf)
    );

    // {guard[3:0], round, input[15:0], expected[7:0], ovf}
    localparam int NN = 18;
    localparam logic [29:0] NAR_VEC [NN] = '{
        {4'd0, 1'b0, 16'h1234, 8'h12, 1'b0},  // R3
        {4'd0, 1'b0, 16'hFF80, 8'hFF, 1'b0},  // R3
        {4'd0, 1'b1, 16'h1280, 8'h13, 1'b0},  // R4
        {4'd0, 1'b1, 16'h127F, 8'h12, 1'b0},  // R4
        {4'd0, 1'b1, 16'h7FFF, 8'h7F, 1'b1},  // R5 rounding carry
        {4'd0, 1'b1, 16'hFF7F, 8'hFF, 1'b0},  // R4
        {4'd2, 1'b0, 16'h0123, 8'h04, 1'b0},  // R3
        {4'd2, 1'b0, 16'h2000, 8'h7F, 1'b1},  // R5
        {4'd2, 1'b0, 16'hE000, 8'h80, 1'b0},  // R3
        {4'd2, 1'b0, 16'hDFC0, 8'h80, 1'b1},  // R5
        {4'd2, 1'b1, 16'h1FE0, 8'h7F, 1'b1},  // R5
        {4'd2, 1'b1, 16'h0020, 8'h01, 1'b0},  // R4
        {4'd8, 1'b0, 16'h007F, 8'h7F, 1'b0},  // R3
        {4'd8, 1'b1, 16'h0080, 8'h7F, 1'b1},  // R4 no rounding at 8
        {4'd8, 1'b0, 16'hFF80, 8'h80, 1'b0},  // R3
        {4'd8, 1'b0, 16'hFF7F, 8'h80, 1'b1},  // R5
        {4'd4, 1'b1, 16'h0008, 8'h01, 1'b0},  // R4
        {4'd4, 1'b1, 16'h0007, 8'h00, 1'b0}   // R4
    };

    // {guard[3:0], input[7:0], expected[15:0]}
    localparam int NW = 7;
    localparam logic [27:0] WID_VEC [NW] = '{
        {4'd0, 8'h81, 16'h8100},  // R1
        {4'd0, 8'h7F, 16'h7F00},  // R1
        {4'd3, 8'h81, 16'hF020},  // R2
        {4'd3, 8'h05, 16'h00A0},  // R2
        {4'd8, 8'h80, 16'hFF80},  // R2
        {4'd8, 8'h7F, 16'h007F},  // R2
        {4'd1, 8'hC0, 16'hE000}   // R2
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8: outputs during reset
        check(wide_out_vld == 0 && wide_out_dat == 0, "R8", "wide reset", int'(wide_out_dat), 0);
        check(nar_out_vld == 0 && nar_out_dat == 0 && nar_out_ovf == 0, "R8", "narrow reset",
              int'(nar_out_dat), 0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check(nar_out_vld == 0 && wide_out_vld == 0, "R8", "idle after reset",
              int'(nar_out_vld), 0);

        // Narrowing table
        for (int i = 0; i < NN; i++) begin
            @(negedge clk);
            cfg_guard  = NAR_VEC[i][29:26];
            cfg_round  = NAR_VEC[i][25];
            nar_in_dat = NAR_VEC[i][24:9];
            nar_in_vld = 1'b1;
            @(posedge clk); #1;
            check(nar_out_vld == 1'b1, "R7", "narrow valid", int'(nar_out_vld), 1);
            check(nar_out_dat == NAR_VEC[i][8:1], "R3/R4/R5", $sformatf("narrow data vec %0d", i),
                  int'(nar_out_dat), int'(NAR_VEC[i][8:1]));
            check(nar_out_ovf == NAR_VEC[i][0], "R6", $sformatf("narrow ovf vec %0d", i),
                  int'(nar_out_ovf), int'(NAR_VEC[i][0]));
            @(negedge clk);
            nar_in_vld = 1'b0;
            nar_in_dat = 16'hA5A5;
            @(posedge clk); #1;
            check(nar_out_vld == 0 && nar_out_ovf == 0, "R6", "ovf drops with valid",
                  int'(nar_out_ovf), 0);
            check(nar_out_dat == NAR_VEC[i][8:1], "R7", "narrow hold", int'(nar_out_dat),
                  int'(NAR_VEC[i][8:1]));
        end

        // Widening table
        for (int i = 0; i < NW; i++) begin
            @(negedge clk);
            cfg_guard   = WID_VEC[i][27:24];
            wide_in_dat = WID_VEC[i][23:16];
            wide_in_vld = 1'b1;
            @(posedge clk); #1;
            check(wide_out_vld == 1'b1, "R7", "wide valid", int'(wide_out_vld), 1);
            check(wide_out_dat == WID_VEC[i][15:0], "R1/R2", $sformatf("wide data vec %0d", i),
                  int'(wide_out_dat), int'(WID_VEC[i][15:0]));
            @(negedge clk);
            wide_in_vld = 1'b0;
            wide_in_dat = 8'h3C;
            @(posedge clk); #1;
            check(wide_out_vld == 0 && wide_out_dat == WID_VEC[i][15:0], "R7", "wide hold",
                  int'(wide_out_dat), int'(WID_VEC[i][15:0]));
        end

        // R7: back-to-back samples, each one clock after its input
        @(negedge clk);
        cfg_guard = 4'd0; cfg_round = 1'b0;
        nar_in_vld = 1'b1; nar_in_dat = 16'h4400;
        @(negedge clk);
        check(nar_out_vld && nar_out_dat == 8'h44, "R7", "b2b first", int'(nar_out_dat), 'h44);
        nar_in_dat = 16'hBB00;
        @(negedge clk);
        check(nar_out_vld && nar_out_dat == 8'hBB, "R7", "b2b second", int'(nar_out_dat), 'hBB);
        nar_in_vld = 1'b0;

        // R8: reset in mid-stream clears everything
        wide_in_vld = 1'b1; wide_in_dat = 8'h55;
        nar_in_vld = 1'b1; nar_in_dat = 16'h7FFF; cfg_round = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(nar_out_vld == 0 && nar_out_dat == 0 && nar_out_ovf == 0, "R8", "narrow mid reset",
              int'(nar_out_dat), 0);
        check(wide_out_vld == 0 && wide_out_dat == 0, "R8", "wide mid reset",
              int'(wide_out_dat), 0);
        wide_in_vld = 1'b0; nar_in_vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(nar_out_vld == 0 && wide_out_vld == 0, "R8", "first cycle after reset",
              int'(nar_out_vld), 0);

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule